// File: doc/BRIEF.md
# Multi-Mode Supervisory Watchdog

This block supervises a host processor with a watchdog counter that advances on an on-chip oscillator tick. The counter changes its behaviour with the system's operating mode. In the two start-up states it waits for an initialization access from the host. In the normal state it enforces a service window: the host must service it late enough in the period, but before the period runs out. In the flash, standby and sleep states it only checks that the period does not run out. In the fail-safe state it is silent.

Service requests arrive as trigger writes from the serial control interface. Each write carries the number of serial clock pulses seen in the frame and a 3-bit code that picks the next period. The block answers with single-cycle pulses: initialization success, initialization failure, a reset request for the system controller, and a time-out interrupt request. The system controller owns the mode changes that follow.

Top module: `mm_watchdog`

## Requirements
- R1: After reset all four output pulses are low, and the stored period code is 7, the longest period.
- R2: Mode codes on `sys_mode`: 0 and 1 select init behaviour; 2 selects window behaviour; 3 selects time-out behaviour; 4 and 5 select time-out behaviour when `wd_off_sel` is 0 and off when it is 1; 6 and 7 select off.
- R3: In init behaviour, a trigger whose clock count is exactly 16 gives an `init_ok` pulse on the next cycle, stores its period code and restarts the count.
- R4: In init behaviour, a trigger with any other clock count, or `INIT_TICKS` ticks without a trigger, gives an `init_fail` pulse on the next cycle and restarts the count.
- R5: The period for code c is `BASE_TICKS` times 2 to the power c ticks.
- R6: In window behaviour, a well-formed trigger that arrives after fewer than half the period's ticks gives a `reset_req` pulse, restarts the count and does not store its code.
- R7: In window behaviour, a well-formed trigger that arrives after half the period or later restarts the count silently and stores its code. A full period of ticks with no trigger gives a `reset_req` pulse and restarts the count.
- R8: In time-out behaviour, any well-formed trigger restarts the count and stores its code. A full period of ticks gives `reset_req`, except in modes 4 and 5 with `tmo_irq_en` high, where it gives `tmo_irq` instead.
- R9: Outside init behaviour, a trigger whose clock count is not 16 has no effect.
- R10: In off behaviour the count is held at zero and no output pulses.
- R11: Any change of `sys_mode` restarts the count, and a tick or trigger in the cycle of the change is ignored.
- R12: A well-formed trigger and the tick that would complete the period, arriving in the same cycle, are resolved in favour of the trigger.
- R13: At most one output pulses in a cycle, and each pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_tick | input | 1 | One-cycle enable per oscillator tick |
| sys_mode | input | 3 | Current operating state of the system controller |
| wd_off_sel | input | 1 | Turns the watchdog off in standby and sleep |
| tmo_irq_en | input | 1 | Time-out raises an interrupt instead of a reset in standby and sleep |
| frm_valid | input | 1 | A trigger write completed this cycle |
| frm_clocks | input | 5 | Serial clock pulses counted in that frame |
| frm_period | input | 3 | Period code carried by the trigger |
| init_ok | output | 1 | Initialization success pulse |
| init_fail | output | 1 | Initialization failure pulse |
| reset_req | output | 1 | System reset request pulse |
| tmo_irq | output | 1 | Time-out interrupt request pulse |

## Verification
Servicing and expiry can fall in the same cycle: a trigger can arrive on the very tick that completes the period. The bench provokes this in window and time-out behaviour by running period-minus-one ticks and then driving a tick and a well-formed trigger together. It judges the result by the absence of any pulse in that cycle, and then by a full fresh period before the next reset request. A mode change that coincides with both a tick and a trigger is provoked the same way. There the bench expects silence and a fresh count that still uses the previously stored code.

// File: rtl/mmwd_pkg.sv
// Package: shared encodings of the multi-mode watchdog.
// Assumes the system controller drives a 3-bit state code.
package mmwd_pkg;

    typedef enum logic [2:0] {
        MD_START    = 3'd0,
        MD_RESTART  = 3'd1,
        MD_NORMAL   = 3'd2,
        MD_FLASH    = 3'd3,
        MD_STANDBY  = 3'd4,
        MD_SLEEP    = 3'd5,
        MD_FAILSAFE = 3'd6,
        MD_SPARE    = 3'd7
    } sys_mode_e;

    typedef enum logic [1:0] {
        BH_OFF     = 2'd0,
        BH_INIT    = 2'd1,
        BH_WINDOW  = 2'd2,
        BH_TIMEOUT = 2'd3
    } wd_beh_e;

endpackage

// File: rtl/mmwd_mode_map.sv
// Module: maps the operating state to a watchdog behaviour.
// Purely combinational; also flags the states where a time-out may be
// turned into an interrupt. Assumes unused state codes mean "off".
module mmwd_mode_map
    import mmwd_pkg::*;
(
    input  logic [2:0] mode,
    input  logic       off_sel,
    output wd_beh_e    beh,
    output logic       irq_cap
);

    // Select behaviour and interrupt capability per state.
    always_comb begin
        beh     = BH_OFF;
        irq_cap = 1'b0;
        case (sys_mode_e'(mode))
            MD_START, MD_RESTART: beh = BH_INIT;
            MD_NORMAL:            beh = BH_WINDOW;
            MD_FLASH:             beh = BH_TIMEOUT;
            MD_STANDBY, MD_SLEEP: begin
                beh     = off_sel ? BH_OFF : BH_TIMEOUT;
                irq_cap = 1'b1;
            end
            default:              beh = BH_OFF;
        endcase
    end

endmodule

// File: rtl/mmwd_period_sel.sv
// Module: turns a period code into a period length in ticks.
// Each entry is the base length doubled once per code step; entries
// are built by a generate loop, so no table is stored.
module mmwd_period_sel #(
    parameter int BASE_TICKS = 4,
    parameter int CODE_W     = 3,
    parameter int PER_W      = 10
) (
    input  logic [CODE_W-1:0] code,
    output logic [PER_W-1:0]  period
);

    localparam int NCODES = 1 << CODE_W;

    logic [PER_W-1:0] tbl [NCODES];

    for (genvar g = 0; g < NCODES; g++) begin : g_entry
        assign tbl[g] = PER_W'(BASE_TICKS << g);
    end

    // Pick the entry for the current code.
    always_comb period = tbl[code];

endmodule

// File: rtl/mmwd_timer.sv
// Module: tick counter of the watchdog.
// Clears on request (clear wins over tick) and saturates at its
// maximum; assumes the caller restarts it before saturation matters.
module mmwd_timer #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Count oscillator ticks since the last restart.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt <= '0;
        else if (clear)                  cnt <= '0;
        else if (tick && cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end

    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt == '0)); // R11

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && tick && cnt != CNT_MAX) |=> (cnt == $past(cnt) + 1'b1)); // R5

endmodule

// File: rtl/mmwd_judge.sv
// Module: decision logic of the watchdog.
// Judges each trigger and each expiring tick against the current
// behaviour, drives the counter restart, keeps the period code and
// registers the four single-cycle output pulses. Assumes frm_valid is
// a one-cycle strobe and cnt comes from a counter cleared by cnt_clear.
module mmwd_judge
    import mmwd_pkg::*;
#(
    parameter int CNT_W        = 9,
    parameter int PER_W        = 10,
    parameter int CODE_W       = 3,
    parameter int CLKS_W       = 5,
    parameter int FRAME_CLOCKS = 16,
    parameter int INIT_TICKS   = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode,
    input  wd_beh_e           beh,
    input  logic              irq_cap,
    input  logic              irq_en,
    input  logic              tick,
    input  logic              frm_valid,
    input  logic [CLKS_W-1:0] frm_clocks,
    input  logic [CODE_W-1:0] frm_code,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [PER_W-1:0]  period,
    output logic              cnt_clear,
    output logic [CODE_W-1:0] code_q,
    output logic              ok_q,
    output logic              fail_q,
    output logic              rst_q,
    output logic              irq_q
);

    logic [2:0] mode_q;
    logic       mode_chg, frame_good, early, per_exp, init_exp;
    logic       load, ok_d, fail_d, rst_d, irq_d;

    // Derive the per-cycle event flags.
    always_comb begin
        mode_chg   = (mode != mode_q);
        frame_good = frm_valid && (32'(frm_clocks) == FRAME_CLOCKS);
        early      = 32'(cnt) < (32'(period) >> 1);
        per_exp    = tick && (32'(cnt) == 32'(period) - 1);
        init_exp   = tick && (32'(cnt) == INIT_TICKS - 1);
    end

    // Decide restart, code load and output pulse for this cycle.
    always_comb begin
        cnt_clear = 1'b0;
        load      = 1'b0;
        ok_d      = 1'b0;
        fail_d    = 1'b0;
        rst_d     = 1'b0;
        irq_d     = 1'b0;
        if (mode_chg) begin
            cnt_clear = 1'b1;
        end else begin
            case (beh)
                BH_INIT: begin
                    if (frm_valid) begin
                        cnt_clear = 1'b1;
                        ok_d      = frame_good;
                        load      = frame_good;
                        fail_d    = !frame_good;
                    end else if (init_exp) begin
                        cnt_clear = 1'b1;
                        fail_d    = 1'b1;
                    end
                end
                BH_WINDOW: begin
                    if (frame_good) begin
                        cnt_clear = 1'b1;
                        rst_d     = early;
                        load      = !early;
                    end else if (per_exp) begin
                        cnt_clear = 1'b1;
                        rst_d     = 1'b1;
                    end
                end
                BH_TIMEOUT: begin
                    if (frame_good) begin
                        cnt_clear = 1'b1;
                        load      = 1'b1;
                    end else if (per_exp) begin
                        cnt_clear = 1'b1;
                        irq_d     = irq_cap && irq_en;
                        rst_d     = !(irq_cap && irq_en);
                    end
                end
                default: cnt_clear = 1'b1;
            endcase
        end
    end

    // Hold the previous mode, the period code and the output pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MD_FAILSAFE;
            code_q <= '1;
            ok_q   <= 1'b0;
            fail_q <= 1'b0;
            rst_q  <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            mode_q <= mode;
            if (load) code_q <= frm_code;
            ok_q   <= ok_d;
            fail_q <= fail_d;
            rst_q  <= rst_d;
            irq_q  <= irq_d;
        end
    end

    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ok_q, fail_q, rst_q, irq_q})); // R13

    AST_RST_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        rst_q |=> !rst_q); // R13

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (beh == BH_OFF) |=> !(ok_q || fail_q || rst_q || irq_q)); // R10

    AST_INIT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (ok_q || fail_q) |-> ($past(beh) == BH_INIT)); // R3

    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> $past(irq_cap && irq_en && beh == BH_TIMEOUT)); // R8

    AST_CHG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> !(ok_q || fail_q || rst_q || irq_q)); // R11

endmodule

// File: rtl/mm_watchdog.sv
// Module: top of the multi-mode supervisory watchdog.
// Connects the mode map, period selector, tick counter and decision
// logic. Assumes osc_tick is already synchronous to clk.
module mm_watchdog #(
    parameter int BASE_TICKS   = 4,
    parameter int INIT_TICKS   = 40,
    parameter int CODE_W       = 3,
    parameter int CLKS_W       = 5,
    parameter int FRAME_CLOCKS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_tick,
    input  logic [2:0]        sys_mode,
    input  logic              wd_off_sel,
    input  logic              tmo_irq_en,
    input  logic              frm_valid,
    input  logic [CLKS_W-1:0] frm_clocks,
    input  logic [CODE_W-1:0] frm_period,
    output logic              init_ok,
    output logic              init_fail,
    output logic              reset_req,
    output logic              tmo_irq
);
    import mmwd_pkg::*;

    localparam int NCODES     = 1 << CODE_W;
    localparam int MAX_PERIOD = BASE_TICKS << (NCODES - 1);
    localparam int SPAN       = (MAX_PERIOD > INIT_TICKS) ? MAX_PERIOD : INIT_TICKS;
    localparam int CNT_W      = $clog2(SPAN);
    localparam int PER_W      = $clog2(MAX_PERIOD + 1);

    wd_beh_e           beh;
    logic              irq_cap, cnt_clear;
    logic [CODE_W-1:0] code_q;
    logic [PER_W-1:0]  period;
    logic [CNT_W-1:0]  cnt;

    mmwd_mode_map u_map (
        .mode    (sys_mode),
        .off_sel (wd_off_sel),
        .beh     (beh),
        .irq_cap (irq_cap)
    );

    mmwd_period_sel #(
        .BASE_TICKS (BASE_TICKS),
        .CODE_W     (CODE_W),
        .PER_W      (PER_W)
    ) u_per (
        .code   (code_q),
        .period (period)
    );

    mmwd_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cnt_clear),
        .tick  (osc_tick),
        .cnt   (cnt)
    );

    mmwd_judge #(
        .CNT_W        (CNT_W),
        .PER_W        (PER_W),
        .CODE_W       (CODE_W),
        .CLKS_W       (CLKS_W),
        .FRAME_CLOCKS (FRAME_CLOCKS),
        .INIT_TICKS   (INIT_TICKS)
    ) u_judge (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (sys_mode),
        .beh        (beh),
        .irq_cap    (irq_cap),
        .irq_en     (tmo_irq_en),
        .tick       (osc_tick),
        .frm_valid  (frm_valid),
        .frm_clocks (frm_clocks),
        .frm_code   (frm_period),
        .cnt        (cnt),
        .period     (period),
        .cnt_clear  (cnt_clear),
        .code_q     (code_q),
        .ok_q       (init_ok),
        .fail_q     (init_fail),
        .rst_q      (reset_req),
        .irq_q      (tmo_irq)
    );

endmodule

// File: tb/mm_watchdog_test.sv
// Bench: directed sweeps over the default configuration with expected
// tick counts computed from BASE_TICKS and INIT_TICKS.
module mm_watchdog_test;

    localparam int BASE  = 4;
    localparam int INITT = 40;
    // pulse codes: ok=8, fail=4, reset=2, irq=1
    localparam int P_OK = 8, P_FAIL = 4, P_RST = 2, P_IRQ = 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [2:0] mode = 3'd6;
    logic       off_sel = 1'b0;
    logic       irq_en = 1'b0;
    logic       fv = 1'b0;
    logic [4:0] fb = 5'd0;
    logic [2:0] fc = 3'd0;
    logic       ok, fl, rr, ti;

    int total = 0;
    int bad = 0;
    int n, w;

    always #2 clk = ~clk;

    mm_watchdog uut (
        .clk(clk), .rst_n(rst_n), .osc_tick(tick), .sys_mode(mode),
        .wd_off_sel(off_sel), .tmo_irq_en(irq_en), .frm_valid(fv),
        .frm_clocks(fb), .frm_period(fc), .init_ok(ok), .init_fail(fl),
        .reset_req(rr), .tmo_irq(ti)
    );

    function automatic int pulses();
        return {28'd0, ok, fl, rr, ti};
    endfunction

    task automatic chk(input bit good, input string req, input int act, input int exp);
        total++;
        if (!good) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one clock: drive at negedge, sample at the next negedge
    task automatic cyc(input logic t, input logic v, input logic [4:0] b, input logic [2:0] c);
        tick = t; fv = v; fb = b; fc = c;
        @(posedge clk);
        @(negedge clk);
        tick = 1'b0; fv = 1'b0;
    endtask

    task automatic count_to_pulse(input int limit, output int cnt_o, output int which);
        cnt_o = 0; which = 0;
        for (int i = 1; i <= limit; i++) begin
            cyc(1'b1, 1'b0, 5'd0, 3'd0);
            if (pulses() != 0) begin
                cnt_o = i; which = pulses();
                return;
            end
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; mode = 3'd6; off_sel = 1'b0; irq_en = 1'b0;
        repeat (2) cyc(1'b0, 1'b0, 5'd0, 3'd0);
        rst_n = 1'b1;
    endtask

    task automatic set_mode(input logic [2:0] m);
        mode = m;
        cyc(1'b0, 1'b0, 5'd0, 3'd0);
    endtask

    task automatic start_with_code(input logic [2:0] c);
        do_reset();
        set_mode(3'd0);
        cyc(1'b0, 1'b1, 5'd16, c);
    endtask

    task automatic run_tests();
        // R1: reset state
        do_reset();
        chk(pulses() == 0, "R1 reset outputs", pulses(), 0);
        // R1 / R5: default code 7 in flash -> 512 ticks
        set_mode(3'd3);
        count_to_pulse(600, n, w);
        chk(n == BASE << 7 && w == P_RST, "R1 default period", n, BASE << 7);
        cyc(1'b0, 1'b0, 5'd0, 3'd0);
        chk(pulses() == 0, "R13 pulse one cycle", pulses(), 0);

        // R5 / R8: flash period sweep
        for (int c = 0; c < 8; c++) begin
            cyc(1'b0, 1'b1, 5'd16, 3'(c));
            chk(pulses() == 0, "R8 flash trigger silent", pulses(), 0);
            count_to_pulse(600, n, w);
            chk(n == (BASE << c) && w == P_RST, "R5 flash period", n, BASE << c);
        end

        // R9: malformed frame ignored in flash (code 0, period 4)
        cyc(1'b0, 1'b1, 5'd16, 3'd0);
        cyc(1'b1, 1'b0, 5'd0, 3'd0);
        cyc(1'b1, 1'b0, 5'd0, 3'd0);
        cyc(1'b0, 1'b1, 5'd0, 3'd5);
        chk(pulses() == 0, "R9 flash bad frame", pulses(), 0);
        count_to_pulse(50, n, w);
        chk(n == 2 && w == P_RST, "R9 flash count kept", n, 2);

        // R12: trigger and expiring tick together in flash
        cyc(1'b0, 1'b1, 5'd16, 3'd1);
        repeat (7) cyc(1'b1, 1'b0, 5'd0, 3'd0);
        cyc(1'b1, 1'b1, 5'd16, 3'd1);
        chk(pulses() == 0, "R12 flash tie", pulses(), 0);
        count_to_pulse(50, n, w);
        chk(n == 8 && w == P_RST, "R12 flash fresh period", n, 8);

        // R8: standby with interrupt enabled and disabled, sleep
        do_reset();
        irq_en = 1'b1;
        set_mode(3'd4);
        cyc(1'b0, 1'b1, 5'd16, 3'd0);
        count_to_pulse(50, n, w);
        chk(n == 4 && w == P_IRQ, "R8 standby irq", w, P_IRQ);
        irq_en = 1'b0;
        count_to_pulse(50, n, w);
        chk(n == 4 && w == P_RST, "R8 standby reset", w, P_RST);
        irq_en = 1'b1;
        set_mode(3'd5);
        count_to_pulse(50, n, w);
        chk(n == 4 && w == P_IRQ, "R8 sleep irq", w, P_IRQ);

        // R10 / R2: off selections stay quiet
        off_sel = 1'b1;
        set_mode(3'd4);
        cyc(1'b0, 1'b1, 5'd16, 3'd0);
        cyc(1'b0, 1'b1, 5'd3, 3'd0);
        chk(pulses() == 0, "R10 off ignores frames", pulses(), 0);
        count_to_pulse(600, n, w);
        chk(n == 0, "R10 standby off", n, 0);
        set_mode(3'd6);
        count_to_pulse(600, n, w);
        chk(n == 0, "R2 failsafe off", n, 0);
        set_mode(3'd7);
        count_to_pulse(600, n, w);
        chk(n == 0, "R2 spare code off", n, 0);
        off_sel = 1'b0;

        // R3 / R4: init behaviour
        do_reset();
        set_mode(3'd0);
        cyc(1'b0, 1'b1, 5'd15, 3'd0);
        chk(pulses() == P_FAIL, "R4 frame 15 clocks", pulses(), P_FAIL);
        count_to_pulse(100, n, w);
        chk(n == INITT && w == P_FAIL, "R4 init timeout", n, INITT);
        set_mode(3'd1);
        cyc(1'b0, 1'b1, 5'd17, 3'd0);
        chk(pulses() == P_FAIL, "R4 frame 17 clocks", pulses(), P_FAIL);
        cyc(1'b0, 1'b1, 5'd16, 3'd0);
        chk(pulses() == P_OK, "R3 restart init ok", pulses(), P_OK);
        set_mode(3'd3);
        count_to_pulse(50, n, w);
        chk(n == 4 && w == P_RST, "R3 code stored", n, 4);

        // R6 / R7: window sweep, code 1 -> period 8, half 4
        for (int e = 0; e < 8; e++) begin
            start_with_code(3'd1);
            set_mode(3'd2);
            repeat (e) cyc(1'b1, 1'b0, 5'd0, 3'd0);
            cyc(1'b0, 1'b1, 5'd16, 3'd1);
            if (e < 4) chk(pulses() == P_RST, "R6 early trigger", pulses(), P_RST);
            else       chk(pulses() == 0, "R7 timely trigger", pulses(), 0);
        end
        count_to_pulse(50, n, w);
        chk(n == 8 && w == P_RST, "R7 window expiry", n, 8);

        // R6: early trigger does not store its code
        start_with_code(3'd1);
        set_mode(3'd2);
        cyc(1'b0, 1'b1, 5'd16, 3'd3);
        count_to_pulse(100, n, w);
        chk(n == 8 && w == P_RST, "R6 code not stored", n, 8);

        // R7: timely trigger stores its code
        start_with_code(3'd1);
        set_mode(3'd2);
        repeat (4) cyc(1'b1, 1'b0, 5'd0, 3'd0);
        cyc(1'b0, 1'b1, 5'd16, 3'd2);
        count_to_pulse(100, n, w);
        chk(n == 16 && w == P_RST, "R7 code stored", n, 16);

        // R9: malformed frame ignored in window
        start_with_code(3'd1);
        set_mode(3'd2);
        repeat (3) cyc(1'b1, 1'b0, 5'd0, 3'd0);
        cyc(1'b0, 1'b1, 5'd15, 3'd1);
        chk(pulses() == 0, "R9 window bad frame", pulses(), 0);
        count_to_pulse(50, n, w);
        chk(n == 5 && w == P_RST, "R9 window count kept", n, 5);

        // R12: tie in window
        start_with_code(3'd1);
        set_mode(3'd2);
        repeat (7) cyc(1'b1, 1'b0, 5'd0, 3'd0);
        cyc(1'b1, 1'b1, 5'd16, 3'd1);
        chk(pulses() == 0, "R12 window tie", pulses(), 0);
        count_to_pulse(50, n, w);
        chk(n == 8 && w == P_RST, "R12 window fresh period", n, 8);

        // R11: mode change swallows tick and trigger, restarts count
        do_reset();
        set_mode(3'd3);
        cyc(1'b0, 1'b1, 5'd16, 3'd2);
        repeat (10) cyc(1'b1, 1'b0, 5'd0, 3'd0);
        irq_en = 1'b1;
        mode = 3'd4;
        cyc(1'b1, 1'b1, 5'd16, 3'd0);
        chk(pulses() == 0, "R11 change cycle quiet", pulses(), 0);
        count_to_pulse(50, n, w);
        chk(n == 16 && w == P_IRQ, "R11 restart old code", n, 16);
    endtask

    initial begin
        fork
            run_tests();
            begin
                repeat (150000) @(posedge clk);
                bad++;
                total++;
                $display("FAIL watchdog expired actual=0 expected=1");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule